// File: doc/BRIEF.md
# Two-Port Programmable Pin Controller

This block drives and samples a bank of general-purpose pins through a small register bus. It serves two ports: a wide port (16 pins by default) and a narrow one (4 pins by default). Each port has a mode register and a value register. The mode register holds a 2-bit field for each pin, and that field makes the pin an input, an output, or neither. The value register holds the level that output pins should drive.

Every write to a mode register rebuilds the port's input and output masks from the new fields. It also recomputes the driven levels at once from the stored value register. Reading a value register returns the synchronized pin levels of input pins merged with the levels that output pins are driving. Pins set to neither read as zero and are never driven.

The bus is a single-cycle register bus. A write completes on the rising clock edge where the write enable is high. Read data is combinational from the address.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, all four registers read 0, and every pin output and output-enable is 0.
- R2: Pin i of a port is controlled by mode bits 2i+1:2i. Mode 2'b10 makes the pin an input. Modes 2'b01 and 2'b11 make it an output, with its output-enable at 1. Mode 2'b00 makes it neither.
- R3: A mode register write discards the previous masks entirely. A pin that is set to 2'b00 stops being driven and reads 0, whatever it was before.
- R4: One clock edge after a mode register write, each pin output equals the stored value bit ANDed with the new output mask.
- R5: A value register write stores bits [PINS-1:0] of the write data. From the next edge, only pins whose output-enable is set drive 1s; every other pin output is 0.
- R6: A value register read returns (synchronized pin inputs AND input mask) OR the driven output bits. Bits above the port width read 0.
- R7: A pin input change becomes visible in value reads after two rising clock edges, and not after one.
- R8: The narrow port uses mode bits 7:0 and value bits 3:0 and follows R2 to R6 on its own masks.
- R9: The word addresses are 0 (wide mode), 1 (wide value), 2 (narrow mode) and 3 (narrow value). A mode register reads back only its 2*PINS low bits. Any address with bits above bit 1 set reads 0, and a write to it is ignored.
- R10: A write to one port's registers leaves the other port's outputs and output-enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| pa_in | input | PA_PINS | Wide port pin levels in |
| pa_out | output | PA_PINS | Wide port driven levels |
| pa_oe | output | PA_PINS | Wide port output-enables |
| pb_in | input | PB_PINS | Narrow port pin levels in |
| pb_out | output | PB_PINS | Narrow port driven levels |
| pb_oe | output | PB_PINS | Narrow port output-enables |

## Verification
A wrong mask shows up one edge after the mode write, in two places: on the output-enable pins and as a wrong merge in value reads. A stale output latch shows up on the pin outputs in the cycle after either a mode write or a value write, so the bench checks the pins right after each write. Synchronizer depth faults show up only in the read data: one edge after an input change the bench expects the old level, and one edge later the new level. Address-decode faults show up as the other port's pins moving, or as a stray write landing from an unmapped address.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   typedef enum logic [1:0] {
      PM_OFF       = 2'b00,
      PM_DRIVE     = 2'b01,
      PM_SENSE     = 2'b10,
      PM_DRIVE_ALT = 2'b11
   } pin_mode_e;

   typedef enum logic [1:0] {
      RS_MODE_A  = 2'd0,
      RS_VALUE_A = 2'd1,
      RS_MODE_B  = 2'd2,
      RS_VALUE_B = 2'd3
   } reg_sel_e;

   localparam int MODE_BITS = 2;

   function automatic logic mode_senses(input logic [1:0] f);
      return pin_mode_e'(f) == PM_SENSE;
   endfunction

   function automatic logic mode_drives(input logic [1:0] f);
      return (pin_mode_e'(f) == PM_DRIVE) || (pin_mode_e'(f) == PM_DRIVE_ALT);
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_width
      $error("gpio_sync: W must be at least 1");
   end
   if (STAGES != 0 && STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be 0 (bypass) or at least 2");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
         end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
         end
      end

      assign q = stage_q[STAGES-1];

      // R7: the last stage always carries what the stage before held one edge earlier
      assert_sync_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> q == $past(stage_q[STAGES-2]));
   end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_pkg::*;
#(
   parameter int PINS        = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      mode_we,
   input  logic                      value_we,
   input  logic [MODE_BITS*PINS-1:0] wdata,
   input  logic [PINS-1:0]           pin_in,
   output logic [PINS-1:0]           pin_out,
   output logic [PINS-1:0]           pin_oe,
   output logic [MODE_BITS*PINS-1:0] mode_rd,
   output logic [PINS-1:0]           value_rd
);

   localparam int CW = MODE_BITS * PINS;

   if (PINS < 1) begin : g_bad_pins
      $error("gpio_port: PINS must be at least 1");
   end
   if (CW > DATA_W) begin : g_bad_fit
      $error("gpio_port: mode register wider than the data bus");
   end

   logic [CW-1:0]   mode_q;
   logic [PINS-1:0] value_q;
   logic [PINS-1:0] sense_mask_q;
   logic [PINS-1:0] drive_mask_q;
   logic [PINS-1:0] drive_q;
   logic [PINS-1:0] sense_new;
   logic [PINS-1:0] drive_new;
   logic [PINS-1:0] pins_synced;

   // decode the incoming mode fields, one per pin
   for (genvar i = 0; i < PINS; i++) begin : g_decode
      assign sense_new[i] = mode_senses(wdata[MODE_BITS*i +: MODE_BITS]);
      assign drive_new[i] = mode_drives(wdata[MODE_BITS*i +: MODE_BITS]);
   end

   gpio_sync #(
      .W      (PINS),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pins_synced)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q       <= '0;
         value_q      <= '0;
         sense_mask_q <= '0;
         drive_mask_q <= '0;
         drive_q      <= '0;
      end else if (mode_we) begin
         mode_q       <= wdata;
         sense_mask_q <= sense_new;
         drive_mask_q <= drive_new;
         drive_q      <= value_q & drive_new;
      end else if (value_we) begin
         value_q <= wdata[PINS-1:0];
         drive_q <= wdata[PINS-1:0] & drive_mask_q;
      end
   end

   assign pin_out  = drive_q;
   assign pin_oe   = drive_mask_q;
   assign mode_rd  = mode_q;
   assign value_rd = (pins_synced & sense_mask_q) | drive_q;

   // R2: no pin may be both sensed and driven
   assert_masks_disjoint_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_mask_q & drive_mask_q) == '0);

   // R5: a pin without output-enable never drives a 1
   assert_drive_within_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);

   // R5: after a value write, the pins show the written bits under the mask
   assert_value_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      value_we && !mode_we |=> pin_out == ($past(wdata[PINS-1:0]) & pin_oe));

   // R4: after a mode write, the pins show the stored value under the new mask
   assert_mode_recalc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mode_we |=> pin_out == ($past(value_q) & pin_oe));

   // R3: a mode write leaves the read-back mode equal to the written fields
   assert_mode_rebuild_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_we |=> mode_rd == $past(wdata));

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
   import gpio_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 32,
   parameter int PA_PINS     = 16,
   parameter int PB_PINS     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [PA_PINS-1:0] pa_in,
   output logic [PA_PINS-1:0] pa_out,
   output logic [PA_PINS-1:0] pa_oe,
   input  logic [PB_PINS-1:0] pb_in,
   output logic [PB_PINS-1:0] pb_out,
   output logic [PB_PINS-1:0] pb_oe
);

   localparam int CW_A = MODE_BITS * PA_PINS;
   localparam int CW_B = MODE_BITS * PB_PINS;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("gpio_ctrl: ADDR_W must be at least 2");
   end
   if (CW_A > DATA_W || CW_B > DATA_W) begin : g_bad_width
      $error("gpio_ctrl: a mode register does not fit the data bus");
   end

   logic     hit;
   reg_sel_e sel;
   logic     a_mode_we, a_value_we, b_mode_we, b_value_we;
   logic [CW_A-1:0]    a_mode_rd;
   logic [PA_PINS-1:0] a_value_rd;
   logic [CW_B-1:0]    b_mode_rd;
   logic [PB_PINS-1:0] b_value_rd;

   if (ADDR_W > 2) begin : g_hi_decode
      assign hit = bus_addr[ADDR_W-1:2] == '0;
   end else begin : g_no_hi
      assign hit = 1'b1;
   end

   assign sel        = reg_sel_e'(bus_addr[1:0]);
   assign a_mode_we  = bus_we && hit && (sel == RS_MODE_A);
   assign a_value_we = bus_we && hit && (sel == RS_VALUE_A);
   assign b_mode_we  = bus_we && hit && (sel == RS_MODE_B);
   assign b_value_we = bus_we && hit && (sel == RS_VALUE_B);

   gpio_port #(
      .PINS        (PA_PINS),
      .SYNC_STAGES (SYNC_STAGES),
      .DATA_W      (DATA_W)
   ) i_port_a (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_we  (a_mode_we),
      .value_we (a_value_we),
      .wdata    (bus_wdata[CW_A-1:0]),
      .pin_in   (pa_in),
      .pin_out  (pa_out),
      .pin_oe   (pa_oe),
      .mode_rd  (a_mode_rd),
      .value_rd (a_value_rd)
   );

   gpio_port #(
      .PINS        (PB_PINS),
      .SYNC_STAGES (SYNC_STAGES),
      .DATA_W      (DATA_W)
   ) i_port_b (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_we  (b_mode_we),
      .value_we (b_value_we),
      .wdata    (bus_wdata[CW_B-1:0]),
      .pin_in   (pb_in),
      .pin_out  (pb_out),
      .pin_oe   (pb_oe),
      .mode_rd  (b_mode_rd),
      .value_rd (b_value_rd)
   );

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         unique case (sel)
            RS_MODE_A:  bus_rdata[CW_A-1:0]    = a_mode_rd;
            RS_VALUE_A: bus_rdata[PA_PINS-1:0] = a_value_rd;
            RS_MODE_B:  bus_rdata[CW_B-1:0]    = b_mode_rd;
            RS_VALUE_B: bus_rdata[PB_PINS-1:0] = b_value_rd;
            default:    bus_rdata = '0;
         endcase
      end
   end

   // R10: writes to the wide port leave the narrow port's pins alone
   assert_port_b_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (a_mode_we || a_value_we) |=> $stable(pb_out) && $stable(pb_oe));

   // R10: writes to the narrow port leave the wide port's pins alone
   assert_port_a_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (b_mode_we || b_value_we) |=> $stable(pa_out) && $stable(pa_oe));

   // R9: a write to an unmapped address changes no pin
   assert_unmapped_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !hit) |=> $stable(pa_out) && $stable(pa_oe)
                           && $stable(pb_out) && $stable(pb_oe));

   // R9: at most one register write strobe per cycle
   assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({a_mode_we, a_value_we, b_mode_we, b_value_we}));

endmodule

// File: tb/test_gpio_ctrl.sv
module test_gpio_ctrl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  bus_addr;
   logic        bus_we;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic [15:0] pa_in, pa_out, pa_oe;
   logic [3:0]  pb_in, pb_out, pb_oe;

   always #5 clk = ~clk;

   gpio_ctrl i_gpio_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pa_in     (pa_in),
      .pa_out    (pa_out),
      .pa_oe     (pa_oe),
      .pb_in     (pb_in),
      .pb_out    (pb_out),
      .pb_oe     (pb_oe)
   );

   typedef struct {
      int          kind;   // 0 read data, 1 pa_out, 2 pa_oe, 3 pb_out, 4 pb_oe
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int    n_checks = 0;
   int    n_fails  = 0;
   logic  rd_req   = 1'b0;

   // reference state, updated from the requirements
   logic [31:0] m_mode_a;
   logic [15:0] m_val_a, m_seen_a;
   logic [7:0]  m_mode_b;
   logic [3:0]  m_val_b, m_seen_b;

   function automatic logic [15:0] drive_of(input logic [31:0] c);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = (c[2*i +: 2] == 2'b01) || (c[2*i +: 2] == 2'b11);
      return r;
   endfunction

   function automatic logic [15:0] sense_of(input logic [31:0] c);
      logic [15:0] r;
      for (int i = 0; i < 16; i++) r[i] = (c[2*i +: 2] == 2'b10);
      return r;
   endfunction

   function automatic logic [31:0] exp_val_a();
      return {16'h0, (m_seen_a & sense_of(m_mode_a)) | (m_val_a & drive_of(m_mode_a))};
   endfunction

   function automatic logic [31:0] exp_val_b();
      logic [15:0] s, d;
      s = sense_of({24'h0, m_mode_b});
      d = drive_of({24'h0, m_mode_b});
      return {28'h0, (m_seen_b & s[3:0]) | (m_val_b & d[3:0])};
   endfunction

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
      case (a)
         4'd0: m_mode_a = d;
         4'd1: m_val_a  = d[15:0];
         4'd2: m_mode_b = d[7:0];
         4'd3: m_val_b  = d[3:0];
         default: ;
      endcase
   endtask

   task automatic fire();
      rd_req = 1'b1;
      #2;
      rd_req = 1'b0;
   endtask

   task automatic chk_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      bus_addr = a;
      it.kind = 0; it.exp = e; it.tag = tag;
      q.push_back(it);
      fire();
   endtask

   task automatic chk_pins(input string tag);
      item_t it;
      logic [15:0] db;
      @(negedge clk);
      db = drive_of({24'h0, m_mode_b});
      it.tag = tag;
      it.kind = 1; it.exp = {16'h0, m_val_a & drive_of(m_mode_a)}; q.push_back(it);
      it.kind = 2; it.exp = {16'h0, drive_of(m_mode_a)};           q.push_back(it);
      it.kind = 3; it.exp = {28'h0, m_val_b & db[3:0]};            q.push_back(it);
      it.kind = 4; it.exp = {28'h0, db[3:0]};                      q.push_back(it);
      fire();
   endtask

   // monitor: pops and compares all items queued for this sampling point
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rd_req) begin
            while (q.size() > 0) begin
               item_t it;
               logic [31:0] act;
               it = q.pop_front();
               case (it.kind)
                  0: act = bus_rdata;
                  1: act = {16'h0, pa_out};
                  2: act = {16'h0, pa_oe};
                  3: act = {28'h0, pb_out};
                  default: act = {28'h0, pb_oe};
               endcase
               n_checks++;
               if (act !== it.exp) begin
                  n_fails++;
                  $display("FAIL %s kind %0d: actual %08h expected %08h", it.tag, it.kind, act, it.exp);
               end
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      pa_in = '0; pb_in = '0;
      m_mode_a = '0; m_val_a = '0; m_seen_a = '0;
      m_mode_b = '0; m_val_b = '0; m_seen_b = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk_rd(4'd0, 32'h0, "R1");
      chk_rd(4'd1, 32'h0, "R1");
      chk_rd(4'd2, 32'h0, "R1");
      chk_rd(4'd3, 32'h0, "R1");
      chk_pins("R1");

      // R2: mixed mode fields on the wide port
      wr(4'd0, 32'h5A3C_96E1);
      chk_pins("R2");
      chk_rd(4'd0, 32'h5A3C_96E1, "R9");

      // R5: value writes drive only enabled pins
      wr(4'd1, 32'hFFFF_FFFF);
      chk_pins("R5");
      wr(4'd1, 32'h0000_A5C3);
      chk_pins("R5");
      chk_rd(4'd1, exp_val_a(), "R6");

      // R7: input change seen after two edges, not one
      @(negedge clk);
      pa_in = 16'hFFFF;
      chk_rd(4'd1, exp_val_a(), "R7");
      m_seen_a = 16'hFFFF;
      chk_rd(4'd1, exp_val_a(), "R7");

      // R6: merge with another input pattern
      @(negedge clk);
      pa_in = 16'h3C69;
      repeat (2) @(negedge clk);
      m_seen_a = 16'h3C69;
      chk_rd(4'd1, exp_val_a(), "R6");

      // R4: new mode recomputes driven levels from stored value
      wr(4'd0, 32'hAAAA_5555);
      chk_pins("R4");
      chk_rd(4'd1, exp_val_a(), "R4");

      // R3: all-off mode clears both masks
      wr(4'd0, 32'h0);
      chk_pins("R3");
      chk_rd(4'd1, 32'h0, "R3");

      // R8: narrow port, upper write bits dropped
      wr(4'd2, 32'hFFFF_FF1B);
      chk_rd(4'd2, 32'h0000_001B, "R9");
      wr(4'd3, 32'hFFFF_FFFF);
      @(negedge clk);
      pb_in = 4'hF;
      repeat (2) @(negedge clk);
      m_seen_b = 4'hF;
      chk_pins("R8");
      chk_rd(4'd3, exp_val_b(), "R8");
      chk_rd(4'd3, 32'h0000_0007, "R8");

      // R10: cross-port isolation
      wr(4'd0, 32'h0000_FFFF);
      wr(4'd1, 32'h0000_1234);
      chk_pins("R10");
      wr(4'd3, 32'h0);
      wr(4'd2, 32'h0);
      chk_pins("R10");
      chk_rd(4'd1, exp_val_a(), "R10");

      // R9: unmapped address ignored and reads 0
      wr(4'd5, 32'hFFFF_FFFF);
      chk_pins("R9");
      chk_rd(4'd5, 32'h0, "R9");
      chk_rd(4'd0, 32'h0000_FFFF, "R9");

      repeat (2) @(negedge clk);
      if (q.size() != 0) begin
         n_fails++;
         $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule